// File: doc/BRIEF.md
# Guarded nonvolatile write controller

This block sits between a CPU bus and a byte-addressable nonvolatile data array. Software sees four registers: an address register, a data register, a control register and a write-only key register. A read strobe copies the addressed byte into the data register. A write is far harder to start. Software must first write the two key bytes, then set write-enable and write-start in a single control write. A write attempted while the power-up hold-off timer is still counting is refused.

A started write drives a one-cycle programming request to the array. The start bit then reads back as 1 for a fixed, parameterised number of clock cycles. When it clears, a one-cycle completion pulse is raised, and this pulse can serve as an interrupt. Bus accesses can be tagged as coming from an external programming port. When the code-protect input is set, such accesses are refused completely. Accesses from the CPU are always served.

Top module: `nvm_write_guard`

## Requirements
- R1: After reset the address, data and control registers read 0: write-enable clear, busy clear and error clear. No array write request or completion pulse is active.
- R2: For PWRT_CYCLES clock cycles after reset is released, a write-start is refused (no array write, busy stays 0) and sets the error flag, even after a correct key sequence.
- R3: Register select 3 is the key register. Writing 55h and then AAh to it arms the controller. A following control write (select 2) with bit 0 (start) and bit 2 (write-enable) both set then raises `arr_we` for exactly one cycle, one cycle after the control write, with `arr_addr` and `arr_wdata` equal to the address (select 0) and data (select 1) registers.
- R4: Control bit 0 reads 1 for exactly WR_CYCLES cycles after an accepted start. `wr_done` pulses for one cycle in the first cycle in which the bit reads 0 again.
- R5: A control write with bit 1 set copies the array byte at the current address into the data register. The copied byte is visible on the next cycle.
- R6: Any accepted bus access other than the next expected key byte returns the key sequence to its start. This covers a wrong key value, a repeated 55h, a write to another register and any read. A later start is then refused.
- R7: A refused start while not busy sets the sticky error flag (control bit 3). The flag survives later successful writes and ordinary control writes. It clears only on a control write with bit 4 set.
- R8: With `code_prot` high, accesses tagged `bus_ext` are refused. They write no register, start nothing, leave the error flag unchanged and read as 0.
- R9: Accesses that are not tagged `bus_ext` work whatever `code_prot` is. External accesses work when `code_prot` is low.
- R10: While a write is busy, writes to the address and data registers and read strobes are ignored. The array receives the original byte.
- R11: Each key sequence allows one control write only. A second start without a new sequence is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (resets the key sequence) |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Selected register, combinational |
| bus_ext | input | 1 | Access comes from the external programming port |
| code_prot | input | 1 | Code protection enabled |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array write data |
| arr_we | output | 1 | One-cycle array write request |
| arr_rdata | input | DATA_W | Array read data for the current address, combinational |
| wr_done | output | 1 | One-cycle write completion pulse |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together. They also assume that `arr_rdata` is a combinational function of `arr_addr`. Finally, `code_prot` and `bus_ext` are expected to change only between accesses. The stimulus drives every access at a falling edge, one strobe at a time, and returns each strobe to idle before the next. The array model answers reads with no delay. The protection inputs are switched only while no strobe is active.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_KEY  = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      UL_IDLE  = 2'd0,
      UL_HALF  = 2'd1,
      UL_ARMED = 2'd2
   } unlock_e;

   localparam int unsigned CB_START = 0;
   localparam int unsigned CB_READ  = 1;
   localparam int unsigned CB_WEN   = 2;
   localparam int unsigned CB_ERR   = 3;
   localparam int unsigned CB_CLR   = 4;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/nvg_unlock.sv
module nvg_unlock
   import nvg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc,
   input  logic       key_wr,
   input  logic [7:0] key_val,
   output logic       armed
);
   unlock_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= UL_IDLE;
      end else if (acc) begin
         if (key_wr && state_q == UL_IDLE && key_val == KEY_FIRST)
            state_q <= UL_HALF;
         else if (key_wr && state_q == UL_HALF && key_val == KEY_SECOND)
            state_q <= UL_ARMED;
         else
            state_q <= UL_IDLE;
      end
   end

   assign armed = (state_q == UL_ARMED);
endmodule

// File: rtl/nvg_countdown.sv
module nvg_countdown #(
   parameter int unsigned CYCLES     = 8,
   parameter bit          START_FULL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic running,
   output logic expire
);
   generate
      if (CYCLES == 0) begin : g_none
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, load};
         assign running = 1'b0;
         assign expire  = 1'b0;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(CYCLES + 1);
         localparam logic [CW-1:0] FULL = CW'(CYCLES);
         logic [CW-1:0] cnt_q;
         logic          exp_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= START_FULL ? FULL : '0;
               exp_q <= 1'b0;
            end else begin
               exp_q <= (cnt_q == CW'(1)) && !load;
               if (load)
                  cnt_q <= FULL;
               else if (cnt_q != '0)
                  cnt_q <= cnt_q - 1'b1;
            end
         end

         assign running = (cnt_q != '0);
         assign expire  = exp_q;
      end
   endgenerate
endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
   import nvg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned WR_CYCLES   = 8,
   parameter int unsigned PWRT_CYCLES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_sel,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ext,
   input  logic              code_prot,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic              arr_we,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              wr_done
);
   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must hold a key byte and the control bits");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("ADDR_W must fit in one bus word");
      end
      if (WR_CYCLES < 1) begin : g_bad_wr_cycles
         $error("WR_CYCLES must be at least one cycle");
      end
   endgenerate

   logic              refused, acc_wr, acc_rd, ctrl_wr;
   logic              busy, pwrt_run, armed;
   logic              start_req, start_ok, start_bad, read_go;
   logic              pwrt_unused_done;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q, ctrl_view;
   logic              wen_q, werr_q, we_q;

   assign refused = bus_ext && code_prot;
   assign acc_wr  = bus_wr && !refused;
   assign acc_rd  = bus_rd && !refused;
   assign ctrl_wr = acc_wr && (bus_sel == SEL_CTRL);

   nvg_unlock u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc_wr || acc_rd),
      .key_wr  (acc_wr && (bus_sel == SEL_KEY)),
      .key_val (bus_wdata[7:0]),
      .armed   (armed)
   );

   nvg_countdown #(.CYCLES(PWRT_CYCLES), .START_FULL(1'b1)) u_pwrt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (1'b0),
      .running (pwrt_run),
      .expire  (pwrt_unused_done)
   );

   nvg_countdown #(.CYCLES(WR_CYCLES), .START_FULL(1'b0)) u_wtimer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_ok),
      .running (busy),
      .expire  (wr_done)
   );

   assign start_req = ctrl_wr && bus_wdata[CB_START] && !busy;
   assign start_ok  = start_req && armed && bus_wdata[CB_WEN] && !pwrt_run;
   assign start_bad = start_req && !start_ok;
   assign read_go   = ctrl_wr && bus_wdata[CB_READ] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         wen_q  <= 1'b0;
         werr_q <= 1'b0;
         we_q   <= 1'b0;
      end else begin
         we_q <= start_ok;
         if (acc_wr && bus_sel == SEL_ADDR && !busy)
            addr_q <= bus_wdata[ADDR_W-1:0];
         if (acc_wr && bus_sel == SEL_DATA && !busy)
            data_q <= bus_wdata;
         else if (read_go)
            data_q <= arr_rdata;
         if (ctrl_wr)
            wen_q <= bus_wdata[CB_WEN];
         if (start_bad)
            werr_q <= 1'b1;
         else if (ctrl_wr && bus_wdata[CB_CLR])
            werr_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_view           = '0;
      ctrl_view[CB_START] = busy;
      ctrl_view[CB_WEN]   = wen_q;
      ctrl_view[CB_ERR]   = werr_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (!refused) begin
         case (bus_sel)
            SEL_ADDR: bus_rdata[ADDR_W-1:0] = addr_q;
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: bus_rdata = ctrl_view;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign arr_addr  = addr_q;
   assign arr_wdata = data_q;
   assign arr_we    = we_q;
endmodule

// File: rtl/nvg_checker.sv
module nvg_checker #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_ext,
   input logic              code_prot,
   input logic [ADDR_W-1:0] addr_q,
   input logic [DATA_W-1:0] data_q,
   input logic              wen_q,
   input logic              busy,
   input logic              armed,
   input logic              pwrt_run,
   input logic              arr_we,
   input logic              wr_done
);
   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!wen_q && !busy && !arr_we && !wr_done));

   // R2
   no_write_in_pwrt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> !pwrt_run);

   // R3
   write_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> $past(armed));

   // R3
   write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |=> !arr_we);

   // R4
   we_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

   // R4
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> wr_done);

   // R8
   ext_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_ext && code_prot) |=> ($stable(addr_q) && $stable(data_q)));

   // R10
   busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(addr_q) && $stable(data_q)));
endmodule

bind nvm_write_guard nvg_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_ext   (bus_ext),
   .code_prot (code_prot),
   .addr_q    (addr_q),
   .data_q    (data_q),
   .wen_q     (wen_q),
   .busy      (busy),
   .armed     (armed),
   .pwrt_run  (pwrt_run),
   .arr_we    (arr_we),
   .wr_done   (wr_done)
);

// File: tb/tb_nvm_write_guard.sv
module tb_nvm_write_guard;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned WR_CYCLES = 8;
   localparam int unsigned PWRT_CYCLES = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic bus_rd = 1'b0;
   logic [1:0] bus_sel = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic bus_ext = 1'b0;
   logic code_prot = 1'b0;
   logic [7:0] arr_addr;
   logic [7:0] arr_wdata;
   logic arr_we;
   logic [7:0] arr_rdata;
   logic wr_done;

   int checks = 0;
   int errors = 0;

   logic [7:0] mem [256];

   always #5 clk = ~clk;

   nvm_write_guard #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .WR_CYCLES(WR_CYCLES), .PWRT_CYCLES(PWRT_CYCLES)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ext(bus_ext), .code_prot(code_prot), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_rdata(arr_rdata),
      .wr_done(wr_done)
   );

   assign arr_rdata = mem[arr_addr];
   always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;

   // address, data pairs for the table walk
   localparam logic [15:0] VEC [6] = '{
      16'h00_3C, 16'hFF_A5, 16'h7F_00, 16'h80_FF, 16'h01_55, 16'h02_AA
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [1:0] s, input logic [7:0] v);
      @(negedge clk);
      bus_sel = s; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [1:0] s);
      @(negedge clk);
      bus_sel = s; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] s, output logic [7:0] v);
      bus_sel = s;
      #1;
      v = bus_rdata;
   endtask

   task automatic unlock_start(input logic [7:0] ctl);
      bwr(2'd3, 8'h55);
      bwr(2'd3, 8'hAA);
      bwr(2'd2, ctl);
   endtask

   task automatic wait_idle(output int n);
      logic [7:0] v;
      n = 0;
      peek(2'd2, v);
      while (v[0] && n < 1000) begin
         n++;
         @(negedge clk);
         peek(2'd2, v);
      end
   endtask

   task automatic read_back(input logic [7:0] a, output logic [7:0] v);
      bwr(2'd0, a);
      bwr(2'd2, 8'h02);
      peek(2'd1, v);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int n;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      peek(2'd0, v); check("R1 addr", v, 8'h00);
      peek(2'd1, v); check("R1 data", v, 8'h00);
      peek(2'd2, v); check("R1 ctrl", v, 8'h00);
      check("R1 arr_we", arr_we, 1'b0);
      check("R1 wr_done", wr_done, 1'b0);

      // R2 start inside power-up hold-off
      unlock_start(8'h05);
      peek(2'd2, v);
      check("R2 busy", v[0], 1'b0);
      check("R2 err", v[3], 1'b1);
      check("R2 arr_we", arr_we, 1'b0);
      bwr(2'd2, 8'h10);
      peek(2'd2, v); check("R7 cleared", v[3], 1'b0);
      repeat (PWRT_CYCLES + 4) @(negedge clk);

      // R3 R4 R5 table walk
      for (int i = 0; i < 6; i++) begin
         logic [7:0] a, d;
         a = VEC[i][15:8];
         d = VEC[i][7:0];
         bwr(2'd0, a);
         bwr(2'd1, d);
         unlock_start(8'h05);
         #1;
         check("R3 arr_we", arr_we, 1'b1);
         check("R3 arr_addr", arr_addr, a);
         check("R3 arr_wdata", arr_wdata, d);
         wait_idle(n);
         check("R4 busy cycles", n, WR_CYCLES);
         check("R4 wr_done", wr_done, 1'b1);
         @(negedge clk); #1;
         check("R4 done one cycle", wr_done, 1'b0);
         read_back(a, v);
         check("R5 read back", v, d);
      end
      read_back(8'h40, v);
      check("R5 untouched byte", v, 8'h40 ^ 8'h5A);

      // R6 wrong key value
      bwr(2'd0, 8'h10); bwr(2'd1, 8'h11);
      bwr(2'd3, 8'h55); bwr(2'd3, 8'h77); bwr(2'd3, 8'hAA); bwr(2'd2, 8'h05);
      peek(2'd2, v);
      check("R6 wrong key busy", v[0], 1'b0);
      check("R6 wrong key err", v[3], 1'b1);
      bwr(2'd2, 8'h10);
      // R6 read in between
      bwr(2'd1, 8'h11);
      bwr(2'd3, 8'h55); brd(2'd0); bwr(2'd3, 8'hAA); bwr(2'd2, 8'h05);
      peek(2'd2, v);
      check("R6 read breaks key", v[0], 1'b0);
      // R6 other register write in between
      bwr(2'd3, 8'h55); bwr(2'd1, 8'h11); bwr(2'd3, 8'hAA); bwr(2'd2, 8'h05);
      peek(2'd2, v);
      check("R6 reg write breaks key", v[0], 1'b0);
      // R6 repeated first key
      bwr(2'd3, 8'h55); bwr(2'd3, 8'h55); bwr(2'd3, 8'hAA); bwr(2'd2, 8'h05);
      peek(2'd2, v);
      check("R6 repeated 55h", v[0], 1'b0);
      read_back(8'h10, v);
      check("R6 array unchanged", v, 8'h10 ^ 8'h5A);

      // R7 sticky error survives a good write and plain control writes
      bwr(2'd2, 8'h05);
      bwr(2'd0, 8'h11); bwr(2'd1, 8'h99);
      unlock_start(8'h05);
      wait_idle(n);
      peek(2'd2, v);
      check("R7 sticky after write", v[3], 1'b1);
      bwr(2'd2, 8'h04);
      peek(2'd2, v);
      check("R7 sticky after ctrl", v[3], 1'b1);
      bwr(2'd2, 8'h14);
      peek(2'd2, v);
      check("R7 clear", v[3], 1'b0);

      // R11 no second start from one key sequence
      bwr(2'd2, 8'h05);
      peek(2'd2, v);
      check("R11 busy", v[0], 1'b0);
      check("R11 err", v[3], 1'b1);
      bwr(2'd2, 8'h10);

      // R3 write-enable clear in start write
      bwr(2'd3, 8'h55); bwr(2'd3, 8'hAA); bwr(2'd2, 8'h01);
      peek(2'd2, v);
      check("R3 wen clear busy", v[0], 1'b0);
      check("R3 wen clear err", v[3], 1'b1);
      bwr(2'd2, 8'h10);

      // R10 writes while busy
      bwr(2'd0, 8'h20); bwr(2'd1, 8'h21);
      unlock_start(8'h05);
      bwr(2'd0, 8'h30); bwr(2'd1, 8'h31); bwr(2'd2, 8'h02);
      wait_idle(n);
      peek(2'd0, v); check("R10 addr kept", v, 8'h20);
      peek(2'd1, v); check("R10 data kept", v, 8'h21);
      read_back(8'h30, v);
      check("R10 no stray write", v, 8'h30 ^ 8'h5A);
      read_back(8'h20, v);
      check("R10 array byte", v, 8'h21);

      // R8 external access under code protection
      @(negedge clk);
      code_prot = 1'b1; bus_ext = 1'b1;
      bwr(2'd0, 8'h44); bwr(2'd1, 8'h45);
      peek(2'd0, v); check("R8 ext read zero", v, 8'h00);
      unlock_start(8'h05);
      bus_ext = 1'b0;
      peek(2'd0, v); check("R8 addr unchanged", v, 8'h20);
      peek(2'd1, v); check("R8 data unchanged", v, 8'h21);
      peek(2'd2, v);
      check("R8 no start", v[0], 1'b0);
      check("R8 err unchanged", v[3], 1'b0);

      // R9 internal access under code protection
      bwr(2'd0, 8'h50); bwr(2'd1, 8'h51);
      unlock_start(8'h05);
      wait_idle(n);
      check("R9 internal write", n, WR_CYCLES);
      read_back(8'h50, v);
      check("R9 internal data", v, 8'h51);
      // R9 external without protection
      @(negedge clk);
      code_prot = 1'b0; bus_ext = 1'b1;
      bwr(2'd0, 8'h60); bwr(2'd1, 8'h61);
      unlock_start(8'h05);
      wait_idle(n);
      check("R9 ext write", n, WR_CYCLES);
      read_back(8'h60, v);
      check("R9 ext data", v, 8'h61);
      bus_ext = 1'b0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule